// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a guest port I/O access has to leave the guest. It takes one access at a time: a 16-bit port number, a 32-bit access-information word that carries the access size in bytes in bits 6:4, the base address of an I/O permission bitmap in memory, the current instruction pointer, the instruction length, and a global enable for I/O interception. The bitmap has one bit for each port. Bit `p mod 8` of the byte at `base + p/8` is set when an access to port `p` must exit.

When interception is enabled and the size is not zero, the block reads one 16-bit little-endian word at `base + port/8`. Because a single fetch covers two bitmap bytes, a multi-byte access near the end of a byte is still checked against every port it touches. When interception is disabled or the size is zero, the block makes no read and reports no exit. In every case it ends with a one-cycle done strobe. The strobe carries the exit flag, the packed access descriptor (the access word with the port number in bits 31:16), and the next instruction address.

Top module: `io_perm_check`

## Requirements
- R1: With `io_icpt_en_i` low, an accepted check issues no memory request. It raises `done_o` one cycle after acceptance with `exit_o` low.
- R2: With the size field `info_i[6:4]` equal to 0, an accepted check issues no memory request. It raises `done_o` one cycle after acceptance with `exit_o` low.
- R3: The bitmap read address is `bmp_base_i + (port_i >> 3)`. It stays stable while `mem_req_valid_o` is high and `mem_req_ready_i` is low.
- R4: The fetched word has bit 0 equal to bit 0 of the byte at the lower address (`mem_rsp_data_i[7:0]`). `exit_o` is high exactly when some bit in positions `port[2:0]` through `port[2:0] + size - 1` of that word is set.
- R5: An access whose bytes run past bit 7 is judged on bits of the upper byte `mem_rsp_data_i[15:8]` as well.
- R6: `exit_info1_o` equals `info_i | (port_i << 16)`.
- R7: `exit_info2_o` equals `ip_i + ilen_i`.
- R8: `done_o` rises one cycle after the cycle in which `mem_rsp_valid_i` is accepted. It is a single-cycle pulse unless a new check is accepted in that same cycle. `req_ready_o` is high only in the idle state and in the done cycle.
- R9: A new check may be accepted in the cycle in which `done_o` is high. The results shown in that cycle belong to the earlier check.
- R10: After reset, `req_ready_o` is high, while `done_o` and `mem_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Check request valid |
| req_ready_o | output | 1 | Block can accept a check |
| port_i | input | 16 | Port number |
| info_i | input | 32 | Access-information word, size in bits 6:4 |
| bmp_base_i | input | 64 | Permission bitmap base address |
| ip_i | input | 64 | Current instruction pointer |
| ilen_i | input | 4 | Instruction length in bytes |
| io_icpt_en_i | input | 1 | Global I/O interception enable |
| mem_req_valid_o | output | 1 | Bitmap read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_addr_o | output | 64 | Bitmap read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 16 | Little-endian bitmap word |
| done_o | output | 1 | One-cycle result strobe |
| exit_o | output | 1 | Access must exit, valid with done_o |
| exit_info1_o | output | 32 | Packed access descriptor |
| exit_info2_o | output | 64 | Next instruction address |

## Verification
The result strobe of one check and the acceptance of the next check can fall in the same cycle. The bench provokes this by holding a second request at the negative edge where `done_o` is seen high. At that edge it checks that `req_ready_o` is high and that the exit flag and both info values still match the first check. It then confirms that the second check completes with its own values. A memory-side stall that holds the read request for several cycles is also driven. In that test, the recorded read address and the completion latency are compared with what R3 and R8 predict.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } io_st_e;
endpackage

// File: rtl/io_perm_eval.sv
module io_perm_eval #(
  parameter int DATA_W = 16,
  parameter int SZ_W   = 3,
  parameter int OFS_W  = 3
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              hit_o
);
  localparam int LIM_W = OFS_W + 2;

  logic [DATA_W-1:0] win;
  logic [LIM_W-1:0]  lo, hi;

  assign lo = LIM_W'(ofs_i);
  assign hi = LIM_W'(ofs_i) + LIM_W'(size_i);

  // window of bits covered by the access, may straddle the byte boundary
  for (genvar g = 0; g < DATA_W; g++) begin : g_win
    assign win[g] = (LIM_W'(g) >= lo) && (LIM_W'(g) < hi);
  end

  assign hit_o = |(word_i & win);
endmodule

// File: rtl/io_perm_ctrl.sv
module io_perm_ctrl
  import io_perm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic skip_i,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic rsp_take_o,
  output logic mem_req_valid_o,
  output logic done_o
);
  io_st_e st_q, st_d;

  assign req_ready_o     = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign accept_o        = req_valid_i && req_ready_o;
  assign mem_req_valid_o = (st_q == ST_FETCH);
  assign rsp_take_o      = (st_q == ST_WAIT) && mem_rsp_valid_i;
  assign done_o          = (st_q == ST_DONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (accept_o) st_d = skip_i ? ST_DONE : ST_FETCH;
        else          st_d = ST_IDLE;
      end
      ST_FETCH: if (mem_req_ready_i) st_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid_i) st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  a_r8_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);
  a_r8_done_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take_o |=> done_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !accept_o) |=> !done_o);
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check #(
  parameter int PORT_W  = 16,
  parameter int INFO_W  = 32,
  parameter int AW      = 64,
  parameter int IPW     = 64,
  parameter int ILEN_W  = 4,
  parameter int DATA_W  = 16,
  parameter int SZ_LSB  = 4,
  parameter int SZ_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [PORT_W-1:0] port_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic [AW-1:0]     bmp_base_i,
  input  logic [IPW-1:0]    ip_i,
  input  logic [ILEN_W-1:0] ilen_i,
  input  logic              io_icpt_en_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              done_o,
  output logic              exit_o,
  output logic [INFO_W-1:0] exit_info1_o,
  output logic [IPW-1:0]    exit_info2_o
);
  localparam int OFS_W      = 3;
  localparam int PORT_SHIFT = INFO_W - PORT_W;

  logic              accept, rsp_take, skip, hit;
  logic [SZ_W-1:0]   size_in;
  logic [OFS_W-1:0]  ofs_q;
  logic [SZ_W-1:0]   size_q;
  logic [AW-1:0]     addr_q;
  logic [INFO_W-1:0] info1_q;
  logic [IPW-1:0]    nip_q;
  logic              exit_q;

  assign size_in = info_i[SZ_LSB +: SZ_W];
  assign skip    = !io_icpt_en_i || (size_in == '0);

  io_perm_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .skip_i          (skip),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .req_ready_o     (req_ready_o),
    .accept_o        (accept),
    .rsp_take_o      (rsp_take),
    .mem_req_valid_o (mem_req_valid_o),
    .done_o          (done_o)
  );

  io_perm_eval #(.DATA_W(DATA_W), .SZ_W(SZ_W), .OFS_W(OFS_W)) u_eval (
    .ofs_i  (ofs_q),
    .size_i (size_q),
    .word_i (mem_rsp_data_i),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q   <= '0;
      size_q  <= '0;
      addr_q  <= '0;
      info1_q <= '0;
      nip_q   <= '0;
      exit_q  <= 1'b0;
    end else begin
      if (accept) begin
        ofs_q   <= port_i[OFS_W-1:0];
        size_q  <= size_in;
        addr_q  <= bmp_base_i + AW'(port_i >> OFS_W);
        info1_q <= info_i | (INFO_W'(port_i) << PORT_SHIFT);
        nip_q   <= ip_i + IPW'(ilen_i);
        exit_q  <= 1'b0;
      end else if (rsp_take) begin
        exit_q  <= hit;
      end
    end
  end

  assign mem_addr_o   = addr_q;
  assign exit_o       = done_o && exit_q;
  assign exit_info1_o = info1_q;
  assign exit_info2_o = nip_q;

  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));
  a_r1_off_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !io_icpt_en_i) |=> (done_o && !exit_o && !mem_req_valid_o));
  a_r2_empty_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && size_in == '0) |=> (done_o && !exit_o && !mem_req_valid_o));
  a_r9_hold_results: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || (!accept && !rsp_take)) |=> $stable(exit_info2_o));
endmodule

// File: tb/io_perm_check_tb.sv
`timescale 1ns/1ps
module io_perm_check_tb;
  localparam logic [63:0] BASE = 64'h0000_0000_0010_0000;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0, req_ready_o;
  logic [15:0] port_i = 0;
  logic [31:0] info_i = 0;
  logic [63:0] bmp_base_i = BASE, ip_i = 0;
  logic [3:0]  ilen_i = 0;
  logic        io_icpt_en_i = 0;
  logic        mem_req_valid_o, mem_req_ready_i = 0;
  logic [63:0] mem_addr_o;
  logic        mem_rsp_valid_i = 0;
  logic [15:0] mem_rsp_data_i = 0;
  logic        done_o, exit_o;
  logic [31:0] exit_info1_o;
  logic [63:0] exit_info2_o;

  int checks = 0, errors = 0;
  int fetches = 0, stall = 0, pend = 0;
  logic [63:0] last_addr = 0;
  logic [7:0]  bmp [0:8192];

  always #4 clk_i = ~clk_i;

  io_perm_check u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [15:0] p, input logic [31:0] inf);
    int sz = int'(inf[6:4]);
    int o  = int'(p[2:0]);
    logic [15:0] w = {bmp[int'(p >> 3) + 1], bmp[int'(p >> 3)]};
    for (int k = o; k < o + sz; k++) if (w[k]) return 1'b1;
    return 1'b0;
  endfunction

  // memory model: ready may be withheld for `stall` cycles, data one cycle after handshake
  initial begin
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid_i = 1;
          mem_rsp_data_i  = {bmp[int'(last_addr - BASE) + 1], bmp[int'(last_addr - BASE)]};
        end
      end
      if (mem_req_valid_o) begin
        if (stall > 0) begin mem_req_ready_i = 0; stall--; end
        else begin
          mem_req_ready_i = 1;
          last_addr = mem_addr_o;
          fetches++;
          pend = 1;
        end
      end else mem_req_ready_i = 0;
    end
  end

  task automatic drive(input logic [15:0] p, input logic [31:0] inf, input logic en,
                       input logic [63:0] ip, input logic [3:0] il);
    req_valid_i = 1; port_i = p; info_i = inf; io_icpt_en_i = en; ip_i = ip; ilen_i = il;
  endtask

  task automatic wait_done(output int cyc);
    @(negedge clk_i);
    req_valid_i = 0;
    cyc = 1;
    while (!done_o && cyc < 60) begin @(negedge clk_i); cyc++; end
  endtask

  task automatic run(input string req, input logic [15:0] p, input logic [31:0] inf, input logic en,
                     input logic [63:0] ip, input logic [3:0] il, input int stl, input bit do_fetch);
    int f0 = fetches, cyc, lat;
    logic e;
    stall = stl;
    e = do_fetch ? exp_hit(p, inf) : 1'b0;
    lat = do_fetch ? 3 + stl : 1;
    drive(p, inf, en, ip, il);
    wait_done(cyc);
    chk(done_o == 1 && cyc == lat, {req, " R8 latency"}, 64'(cyc), 64'(lat));
    chk(exit_o == e, {req, " R4 exit"}, 64'(exit_o), 64'(e));
    chk(exit_info1_o == (inf | {p, 16'h0}), {req, " R6 info1"}, 64'(exit_info1_o), 64'(inf | {p, 16'h0}));
    chk(exit_info2_o == ip + 64'(il), {req, " R7 info2"}, exit_info2_o, ip + 64'(il));
    chk((fetches - f0) == (do_fetch ? 1 : 0), {req, " fetch count"}, 64'(fetches - f0), 64'(do_fetch));
    if (do_fetch)
      chk(last_addr == BASE + 64'(p >> 3), {req, " R3 address"}, last_addr, BASE + 64'(p >> 3));
    @(negedge clk_i);
    chk(!done_o, {req, " R8 single pulse"}, 64'(done_o), 0);
  endtask

  task automatic t_reset;
    chk(req_ready_o == 1, "R10 ready", 64'(req_ready_o), 1);
    chk(done_o == 0, "R10 done", 64'(done_o), 0);
    chk(mem_req_valid_o == 0, "R10 memreq", 64'(mem_req_valid_o), 0);
  endtask

  task automatic t_back_to_back;
    int cyc;
    logic [31:0] ia = 32'h0000_0010 | 32'h8;
    logic [31:0] ib = 32'h0000_0040;
    drive(16'h0060, ia, 1, 64'h5000, 4'd2);
    wait_done(cyc);
    chk(req_ready_o == 1, "R9 ready in done cycle", 64'(req_ready_o), 1);
    drive(16'h0071, ib, 1, 64'h6000, 4'd3);
    #1;
    chk(exit_o == exp_hit(16'h0060, ia), "R9 first exit", 64'(exit_o), 64'(exp_hit(16'h0060, ia)));
    chk(exit_info2_o == 64'h5002, "R9 first info2", exit_info2_o, 64'h5002);
    chk(exit_info1_o == (ia | 32'h0060_0000), "R9 first info1", 64'(exit_info1_o), 64'(ia | 32'h0060_0000));
    wait_done(cyc);
    chk(done_o == 1 && cyc == 3, "R9 second latency", 64'(cyc), 3);
    chk(exit_o == exp_hit(16'h0071, ib), "R9 second exit", 64'(exit_o), 64'(exp_hit(16'h0071, ib)));
    chk(exit_info2_o == 64'h6003, "R9 second info2", exit_info2_o, 64'h6003);
    @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i <= 8192; i++) bmp[i] = 8'h00;
    bmp[16'h0060 >> 3]  = 8'h01;            // port 0x60 blocked
    bmp[16'h0071 >> 3]  = 8'h04;            // port 0x72 blocked
    bmp[16'h0400 >> 3]  = 8'h01;            // port 0x400 blocked (next byte of 0x3fe)
    bmp[16'h0208 >> 3]  = 8'h04;            // port 0x20a blocked
    bmp[16'hfff8 >> 3]  = 8'h80;            // port 0xffff blocked
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    run("R1 disabled",       16'h0060, 32'h10, 0, 64'h1000, 4'd1, 0, 0);
    run("R2 size zero",      16'h0060, 32'h00, 1, 64'h1100, 4'd2, 0, 0);
    run("R4 hit byte",       16'h0060, 32'h10, 1, 64'h1200, 4'd1, 0, 1);
    run("R4 miss byte",      16'h0061, 32'h10, 1, 64'h1300, 4'd1, 0, 1);
    run("R5 cross hit",      16'h03fe, 32'h40, 1, 64'h1400, 4'd2, 0, 1);
    run("R5 cross miss",     16'h03fe, 32'h20, 1, 64'h1500, 4'd2, 0, 1);
    run("R4 2byte miss",     16'h0208, 32'h20, 1, 64'h1600, 4'd3, 0, 1);
    run("R4 4byte hit",      16'h0208, 32'h41, 1, 64'h1700, 4'd4, 0, 1);
    run("R3 stall",          16'h0400, 32'h10, 1, 64'hffff_fff0, 4'd15, 3, 1);
    run("R6 top port",       16'hffff, 32'h1d, 1, 64'h1800, 4'd1, 1, 1);
    t_back_to_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule